// File: doc/BRIEF.md
# Optical Disc Sector Assembler

This block builds one raw optical-disc sector of 2352 bytes and sends it out one byte per cycle. Its upstream is a byte stream with valid/ready handshaking, which carries a 4-byte header followed by 2048 user bytes. The block wraps that payload in a fixed frame:

- a 12-byte synchronisation preamble,
- the header and the user bytes, passed through in order,
- a 32-bit check value over everything emitted so far,
- an 8-byte zero field,
- a zero-filled region that holds the place of the error-correction parity.

The block stays idle until the upstream presents a byte. It then runs one full sector. A strobe marks the first output byte and another marks the last. While the header and payload are being copied, the output waits whenever the upstream has no byte ready. The preamble and every field after the payload are generated locally, so they stream on back-to-back cycles. After the last byte the block spends one idle cycle before it can begin the next sector.

Top module: `sector_asm`

## Requirements
- R1: After reset, `out_valid`, `out_sos`, `out_eos` and `in_ready` are all 0.
- R2: While idle, the block emits nothing. A sector begins only when `in_valid` is 1 in an idle cycle. The first byte of the sector leaves with `out_sos` = 1.
- R3: Output bytes 0 to 11 are the preamble: 00h, then ten bytes of FFh, then 00h. They leave on 12 consecutive cycles.
- R4: Output bytes 12 to 15 are the 4 header bytes and bytes 16 to 2063 are the 2048 user bytes, in arrival order. `in_ready` is 1 only while those fields are being filled, so exactly 2052 input bytes are taken per sector.
- R5: During the header and payload fields, a cycle with `in_valid` = 0 moves nothing: on the following cycle `out_valid` is 0.
- R6: Output bytes 2064 to 2067 carry a 32-bit check value, least significant byte first. It is computed as follows:
  - It covers output bytes 0 to 2063.
  - Each byte is processed least significant bit first, with the register starting at 0 and no final inversion.
  - The bit-reversed feedback constant is D8018001h, which corresponds to the generator (x^16+x^15+x^2+1)(x^16+x^2+x+1).
- R7: Output bytes 2068 to 2351 (8 zero bytes followed by 276 parity bytes) are all 00h.
- R8: Every sector has exactly 2352 valid bytes. `out_sos` is 1 only on byte 0 and `out_eos` is 1 only on byte 2351.
- R9: The cycle after `out_eos` has `out_valid` = 0.
- R10: Bytes 2064 to 2351 leave on consecutive cycles, whatever `in_valid` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Upstream byte present |
| in_data | input | 8 | Upstream header/payload byte |
| in_ready | output | 1 | Block takes the upstream byte this cycle |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sos | output | 1 | First byte of a sector |
| out_eos | output | 1 | Last byte of a sector |

## Verification
The hardest case to reach from the ports is an upstream stall that lands on a field boundary. Two examples are a stall on the last header byte and a stall on the final payload byte just before the check-value field begins. Such a stall must neither duplicate nor drop a byte, and it must not disturb the running check value. To reach these cases, the bench sends whole sectors under three gating patterns: no gaps, a gap on every third cycle, and a pseudo-random gap pattern from an LFSR. Between them these patterns place stalls on every field edge. For each sector the bench compares all 2352 bytes against a frame and check value it computes arithmetically.

// File: rtl/sa_pkg.sv
// Package: shared field encoding and the byte-wise check-value step for the
// sector assembler. Assumes reflected (LSB-first) processing.
package sa_pkg;

    typedef enum logic [2:0] {
        FLD_IDLE = 3'd0,
        FLD_SYNC = 3'd1,
        FLD_HDR  = 3'd2,
        FLD_DATA = 3'd3,
        FLD_CRC  = 3'd4,
        FLD_ZERO = 3'd5,
        FLD_PAR  = 3'd6
    } field_e;

    localparam logic [31:0] CRC_POLY_REFL = 32'hD801_8001;

    // One byte of the reflected check-value update, bit 0 first.
    function automatic logic [31:0] crc_step(input logic [31:0] c_in,
                                             input logic [7:0]  b);
        logic [31:0] c;
        c = c_in ^ {24'd0, b};
        for (int k = 0; k < 8; k++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/sa_seq.sv
// Module: sa_seq
// Walks the sector fields in order and keeps the byte index inside the
// current field. The index moves on every cycle in locally generated fields
// and only on accepted input bytes in the header and payload fields.
// Assumes every field length is at least 1.
module sa_seq
    import sa_pkg::*;
#(
    parameter int SYNC_LEN = 12,
    parameter int HDR_LEN  = 4,
    parameter int DATA_LEN = 2048,
    parameter int CRC_LEN  = 4,
    parameter int ZERO_LEN = 8,
    parameter int PAR_LEN  = 276,
    localparam int MAX_LEN = (DATA_LEN > PAR_LEN) ? DATA_LEN : PAR_LEN,
    localparam int IDX_W   = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output field_e           field,
    output logic [IDX_W-1:0] idx,
    output logic             last,
    output logic             step,
    output logic             start,
    output logic             in_ready
);

    logic [IDX_W-1:0] cur_len;

    // Length of the field currently being emitted.
    always_comb begin
        case (field)
            FLD_SYNC: cur_len = IDX_W'(SYNC_LEN);
            FLD_HDR:  cur_len = IDX_W'(HDR_LEN);
            FLD_DATA: cur_len = IDX_W'(DATA_LEN);
            FLD_CRC:  cur_len = IDX_W'(CRC_LEN);
            FLD_ZERO: cur_len = IDX_W'(ZERO_LEN);
            FLD_PAR:  cur_len = IDX_W'(PAR_LEN);
            default:  cur_len = IDX_W'(1);
        endcase
    end

    // Decide whether a byte leaves this cycle and whether input is taken.
    always_comb begin
        in_ready = (field == FLD_HDR) || (field == FLD_DATA);
        case (field)
            FLD_IDLE:          step = 1'b0;
            FLD_HDR, FLD_DATA: step = in_valid;
            default:           step = 1'b1;
        endcase
        last  = (idx == cur_len - IDX_W'(1));
        start = (field == FLD_IDLE) && in_valid;
    end

    // Advance the field and the index within it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field <= FLD_IDLE;
            idx   <= '0;
        end else if (start) begin
            field <= FLD_SYNC;
            idx   <= '0;
        end else if (step) begin
            if (last) begin
                idx <= '0;
                case (field)
                    FLD_SYNC: field <= FLD_HDR;
                    FLD_HDR:  field <= FLD_DATA;
                    FLD_DATA: field <= FLD_CRC;
                    FLD_CRC:  field <= FLD_ZERO;
                    FLD_ZERO: field <= FLD_PAR;
                    default:  field <= FLD_IDLE;
                endcase
            end else begin
                idx <= idx + IDX_W'(1);
            end
        end
    end

    p_idx_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (field != FLD_IDLE) |-> (idx < cur_len));

    p_hold_on_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (((field == FLD_HDR) || (field == FLD_DATA)) && !in_valid)
        |=> ($stable(idx) && $stable(field)));

    p_no_stall_trailer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((field == FLD_CRC) || (field == FLD_ZERO)) |=> (field != FLD_IDLE));

endmodule

// File: rtl/sa_crc.sv
// Module: sa_crc
// Running 32-bit check value over the preamble, header and payload bytes.
// It clears when a sector starts and folds in each byte emitted in the
// covered fields. Assumes start and upd are never high together.
module sa_crc
    import sa_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        upd,
    input  logic [7:0]  byte_in,
    output logic [31:0] crc
);

    // Clear on sector start and accumulate on covered bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc <= '0;
        end else if (start) begin
            crc <= '0;
        end else if (upd) begin
            crc <= crc_step(crc, byte_in);
        end
    end

    p_clear_on_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (crc == 32'd0));

    p_hold_when_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !upd) |=> $stable(crc));

endmodule

// File: rtl/sa_mux.sv
// Module: sa_mux
// Selects the byte that belongs at the current field and index. It produces
// the preamble pattern, passes input through, slices out the check value LSB
// first, and returns zero for the padding and parity regions.
module sa_mux
    import sa_pkg::*;
#(
    parameter int SYNC_LEN = 12,
    parameter int IDX_W    = 12
) (
    input  field_e           field,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       in_data,
    input  logic [31:0]      crc,
    output logic [7:0]       byte_out
);

    logic sync_edge;
    logic [1:0] crc_sel;

    // Pick the outgoing byte for this field position.
    always_comb begin
        sync_edge = (idx == '0) || (idx == IDX_W'(SYNC_LEN - 1));
        crc_sel   = idx[1:0];
        case (field)
            FLD_SYNC:          byte_out = sync_edge ? 8'h00 : 8'hFF;
            FLD_HDR, FLD_DATA: byte_out = in_data;
            FLD_CRC:           byte_out = crc[8*crc_sel +: 8];
            default:           byte_out = 8'h00;
        endcase
    end

endmodule

// File: rtl/sector_asm.sv
// Module: sector_asm (top)
// Assembles one raw optical sector per run:
//   preamble | header | payload | check value | zero pad | parity placeholder.
// The output is registered, so each byte leaves one cycle after the cycle in
// which it is selected. There is no downstream backpressure; the output
// stalls only when the upstream is empty during header or payload.
module sector_asm
    import sa_pkg::*;
#(
    parameter int SYNC_LEN = 12,
    parameter int HDR_LEN  = 4,
    parameter int DATA_LEN = 2048,
    parameter int CRC_LEN  = 4,
    parameter int ZERO_LEN = 8,
    parameter int PAR_LEN  = 276,
    localparam int SECTOR_LEN = SYNC_LEN + HDR_LEN + DATA_LEN + CRC_LEN
                                + ZERO_LEN + PAR_LEN,
    localparam int MAX_LEN = (DATA_LEN > PAR_LEN) ? DATA_LEN : PAR_LEN,
    localparam int IDX_W   = $clog2(MAX_LEN + 1),
    localparam int CNT_W   = $clog2(SECTOR_LEN + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_sos,
    output logic       out_eos
);

    field_e           field;
    logic [IDX_W-1:0] idx;
    logic             last;
    logic             step;
    logic             start;
    logic [31:0]      crc;
    logic [7:0]       sel_byte;
    logic             crc_upd;

    sa_seq #(
        .SYNC_LEN(SYNC_LEN), .HDR_LEN(HDR_LEN), .DATA_LEN(DATA_LEN),
        .CRC_LEN(CRC_LEN), .ZERO_LEN(ZERO_LEN), .PAR_LEN(PAR_LEN)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .field(field), .idx(idx), .last(last), .step(step),
        .start(start), .in_ready(in_ready)
    );

    // The check value covers only the preamble, header and payload fields.
    always_comb begin
        crc_upd = step && ((field == FLD_SYNC) || (field == FLD_HDR)
                           || (field == FLD_DATA));
    end

    sa_crc u_crc (
        .clk(clk), .rst_n(rst_n), .start(start), .upd(crc_upd),
        .byte_in(sel_byte), .crc(crc)
    );

    sa_mux #(.SYNC_LEN(SYNC_LEN), .IDX_W(IDX_W)) u_mux (
        .field(field), .idx(idx), .in_data(in_data), .crc(crc),
        .byte_out(sel_byte)
    );

    // Register the outgoing byte and the sector boundary strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= 8'h00;
            out_sos   <= 1'b0;
            out_eos   <= 1'b0;
        end else begin
            out_valid <= step;
            out_data  <= step ? sel_byte : 8'h00;
            out_sos   <= step && (field == FLD_SYNC) && (idx == '0);
            out_eos   <= step && (field == FLD_PAR) && last;
        end
    end

    // Checking aid: bytes emitted since the last start-of-sector strobe.
    logic [CNT_W-1:0] chk_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)                chk_cnt <= '0;
        else if (out_sos)          chk_cnt <= CNT_W'(1);
        else if (out_valid)        chk_cnt <= chk_cnt + CNT_W'(1);
    end

    p_sos_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_sos |-> (out_valid && !out_eos));

    p_eos_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_eos |-> (out_valid && (chk_cnt == CNT_W'(SECTOR_LEN - 1))));

    p_gap_after_eos_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_eos |=> !out_valid);

    p_stall_no_output_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> !out_valid);

    p_sync_first_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_sos |-> (out_data == 8'h00));

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_sos && !out_eos));

endmodule

// File: tb/tb_sector_asm.sv
// Bench: sends several full sectors under different upstream gating patterns
// and compares every output byte against a frame built in the bench.
module tb_sector_asm;

    localparam int SECT = 2352;
    localparam int NIN  = 2052;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready, out_valid, out_sos, out_eos;
    logic [7:0] out_data;

    int tests = 0;
    int fails = 0;
    logic [7:0] src  [0:NIN-1];
    logic [7:0] expv [0:SECT-1];
    logic [7:0] got  [0:SECT-1];
    int  n_got, n_acc, sos_bad, eos_bad, sync_gaps, tail_gaps;
    bit  done_run;

    sector_asm dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_sos(out_sos), .out_eos(out_eos)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Build the source bytes and the expected frame from the requirements.
    task automatic build(input int seed);
        logic [31:0] c;
        for (int i = 0; i < NIN; i++) src[i] = 8'((i * 7 + seed) ^ (i >> 5) ^ (seed >> 3));
        for (int i = 0; i < SECT; i++) expv[i] = 8'h00;
        for (int i = 1; i < 11; i++) expv[i] = 8'hFF;       // R3 preamble
        for (int i = 0; i < NIN; i++) expv[12 + i] = src[i]; // R4
        c = 32'd0;
        for (int i = 0; i < 2064; i++) begin                 // R6
            c = c ^ {24'd0, expv[i]};
            for (int k = 0; k < 8; k++)
                c = c[0] ? ((c >> 1) ^ 32'hD8018001) : (c >> 1);
        end
        for (int i = 0; i < 4; i++) expv[2064 + i] = c[8*i +: 8];
    endtask

    // Upstream driver with a gating pattern.
    task automatic drive(input int mode);
        int pos = 0;
        bit pend = 0;
        logic [15:0] lf = 16'hACE1;
        int cyc = 0;
        while (pos < NIN) begin
            @(negedge clk);
            if (pend) pos++;
            pend = 0;
            cyc++;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (pos < NIN) begin
                in_valid = (mode == 0) ? 1'b1 :
                           (mode == 1) ? (cyc % 3 != 1) : (lf[0] | lf[3]);
                in_data  = in_valid ? src[pos] : 8'h5A;
                pend = in_valid && in_ready;
                if (pend) n_acc++;
            end else begin
                in_valid = 1'b0;
            end
        end
        in_valid = 1'b0;
    endtask

    // Output monitor: collects one sector.
    task automatic monitor();
        int last_pos = -1, cyc = 0, last_cyc = 0;
        while (!done_run) begin
            @(negedge clk);
            cyc++;
            if (out_valid) begin
                if (n_got < SECT) got[n_got] = out_data;
                if (out_sos != (n_got == 0)) sos_bad++;
                if (out_eos != (n_got == SECT - 1)) eos_bad++;
                if (n_got > 0 && n_got < 12 && cyc != last_cyc + 1) sync_gaps++;
                if (n_got > 2064 && cyc != last_cyc + 1) tail_gaps++;
                last_cyc = cyc;
                n_got++;
                if (out_eos) done_run = 1;
            end
        end
        @(negedge clk);
        check(!out_valid, "R9", "valid after eos", out_valid, 0);
    endtask

    task automatic run_sector(input int seed, input int mode);
        int bad_sync = 0, bad_pay = 0, bad_crc = 0, bad_tail = 0;
        build(seed);
        n_got = 0; n_acc = 0; sos_bad = 0; eos_bad = 0;
        sync_gaps = 0; tail_gaps = 0; done_run = 0;
        fork
            drive(mode);
            monitor();
        join
        for (int i = 0; i < SECT; i++) begin
            if (got[i] !== expv[i]) begin
                if (i < 12) bad_sync++;
                else if (i < 2064) bad_pay++;
                else if (i < 2068) bad_crc++;
                else bad_tail++;
            end
        end
        check(n_got == SECT, "R8", "sector length", n_got, SECT);
        check(sos_bad == 0 && eos_bad == 0, "R8", "strobe placement", sos_bad + eos_bad, 0);
        check(bad_sync == 0 && sync_gaps == 0, "R3", "preamble", bad_sync + sync_gaps, 0);
        check(bad_pay == 0, "R4", "header/payload bytes", bad_pay, 0);
        check(n_acc == NIN, "R4", "bytes taken", n_acc, NIN);
        check(bad_crc == 0, "R6", "check value",
              {got[2067], got[2066], got[2065], got[2064]},
              {expv[2067], expv[2066], expv[2065], expv[2064]});
        check(bad_tail == 0, "R7", "zero and parity", bad_tail, 0);
        check(tail_gaps == 0, "R10", "trailer gaps", tail_gaps, 0);
    endtask

    // Idle check: nothing leaves while in_valid stays low.
    task automatic idle_quiet(input int n);
        int seen = 0;
        in_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (out_valid || in_ready) seen++;
        end
        check(seen == 0, "R2", "activity while idle", seen, 0);
    endtask

    // Stall check: a gap in the payload produces no byte on the next cycle.
    int stall_viol = 0;
    always @(negedge clk) begin
        if (rst_n && in_ready && !in_valid) begin
            @(negedge clk);
            if (out_valid) stall_viol++;
        end
    end

    initial begin
        fork
            begin
                #2_000_000;
                fails++;
                tests++;
                $display("FAIL watchdog expired");
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        join_none
        repeat (3) @(negedge clk);
        check(!out_valid && !out_sos && !out_eos && !in_ready, "R1",
              "reset outputs", {out_valid, out_sos, out_eos, in_ready}, 0);
        rst_n = 1'b1;
        idle_quiet(10);
        run_sector(3, 0);
        idle_quiet(5);
        run_sector(91, 1);
        idle_quiet(5);
        run_sector(200, 2);
        run_sector(0, 1);
        check(stall_viol == 0, "R5", "output during stall", stall_viol, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule